// File: doc/BRIEF.md
# Phase-Accumulator PWM Channel with Staged Settings

This block drives one pulse-width-modulated output from a single 32-bit control word. The output frequency comes from a phase accumulator: every clock, while the channel is on, a programmable increment (the base unit) is added to it. The top byte of the accumulator is compared against an 8-bit divisor held in inverted form, so a larger divisor gives a shorter high time.

New base-unit and divisor values are first written into a staged copy. Software then raises an update flag. At the next output-cycle boundary the hardware copies the staged values into the active copy and clears the flag. An output-cycle boundary is either an accumulator carry or the first clock after the channel is switched on. Until the flag clears, later writes cannot touch the staged fields. This means an update can never tear a running cycle.

Top module: `pwm_accum_top`

## Requirements
- R1: Bit 31 of the control word is the enable. While it is 0, the output is low and the accumulator is held at zero.
- R2: Bit 30 is the update flag. A write sets it from bit 30 of the data only when it is currently 0. At the next cycle boundary (accumulator carry-out, or the first clock after enable rises), the staged fields are copied to the active copy and the flag returns to 0.
- R3: The base-unit field occupies bits [8 +: BASE_UNIT_BITS]. The accumulator is BASE_UNIT_BITS+8 bits wide and adds the active base unit once per clock, so one output cycle spans 2^(BASE_UNIT_BITS+8)/base_unit clocks (1024 clocks for base unit 64 at the default width of 8).
- R4: Bits 7:0 hold the inverted on-time divisor. The output is high when the accumulator's top byte is strictly greater than the active divisor. A divisor of 255 therefore keeps the output always low, and a divisor of 0 keeps it high except while the top byte is 0.
- R5: A base unit of 0 stops the accumulator. After that value takes effect, no further cycle boundary occurs and the output stays low from an accumulator of zero.
- R6: While the flag is set, a write still updates the enable bit but leaves the staged base-unit field, the staged divisor field and the flag unchanged.
- R7: A read returns {enable, flag, zeros, staged base unit, staged divisor}, with the divisor in bits 7:0 and the base unit from bit 8.
- R8: Raising the enable restarts the accumulator from zero, so the first cycle has full length. With base unit 128 and divisor 64 written together with enable, the output first goes high 132 clocks after the write edge.
- R9: The asynchronous active-low reset clears the control word, both copies and the accumulator, and drives the output low.
- R10: The output is registered: it reflects the accumulator and active divisor one clock earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Write strobe for the control word |
| wr_data_i | input | 32 | Control word write data |
| rd_data_o | output | 32 | Control word read-back |
| pwm_o | output | 1 | Registered PWM output |

## Verification
The assertions rely on two things about the write data: the width parameter leaves the base-unit field below bit 30, and writes arrive as single-clock strobes sampled at the edge. The stimulus drives every write from the falling edge and holds it for exactly one rising edge. It raises the flag only together with new settings, and it uses base units that divide the accumulator range evenly, so cycle lengths come out exact. A second write issued on the clock right after a flagged write lands while the flag is set, whatever the accumulator phase. This makes the ignored-write case deterministic.

// File: rtl/pwm_accum_pkg.sv
package pwm_accum_pkg;
  localparam int unsigned CTRL_W  = 32;
  localparam int unsigned EN_BIT  = 31;
  localparam int unsigned UPD_BIT = 30;
  localparam int unsigned BU_LSB  = 8;
  localparam int unsigned OTD_W   = 8;
endpackage

// File: rtl/pwm_ctrl_reg.sv
module pwm_ctrl_reg
  import pwm_accum_pkg::*;
#(
  parameter int unsigned BU_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [CTRL_W-1:0] wr_data_i,
  input  logic              start_i,
  output logic              en_o,
  output logic [BU_W-1:0]   bu_act_o,
  output logic [OTD_W-1:0]  otd_act_o,
  output logic [CTRL_W-1:0] rd_data_o
);
  logic              en_q, upd_q;
  logic [BU_W-1:0]   bu_stage_q, bu_act_q;
  logic [OTD_W-1:0]  otd_stage_q, otd_act_q;
  logic              commit;

  assign commit = upd_q & start_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q        <= 1'b0;
      upd_q       <= 1'b0;
      bu_stage_q  <= '0;
      otd_stage_q <= '0;
    end else begin
      if (wr_en_i) en_q <= wr_data_i[EN_BIT];
      if (upd_q) begin
        if (start_i) upd_q <= 1'b0;
      end else if (wr_en_i) begin
        // staged fields writable only while no update is pending
        upd_q       <= wr_data_i[UPD_BIT];
        bu_stage_q  <= wr_data_i[BU_LSB +: BU_W];
        otd_stage_q <= wr_data_i[OTD_W-1:0];
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bu_act_q  <= '0;
      otd_act_q <= '0;
    end else if (commit) begin
      bu_act_q  <= bu_stage_q;
      otd_act_q <= otd_stage_q;
    end
  end

  always_comb begin
    rd_data_o                    = '0;
    rd_data_o[EN_BIT]            = en_q;
    rd_data_o[UPD_BIT]           = upd_q;
    rd_data_o[BU_LSB +: BU_W]    = bu_stage_q;
    rd_data_o[OTD_W-1:0]         = otd_stage_q;
  end

  assign en_o      = en_q;
  assign bu_act_o  = bu_act_q;
  assign otd_act_o = otd_act_q;

  p_flag_clears_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd_q && start_i) |=> !upd_q);
  p_commit_copies_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd_q && start_i) |=> (bu_act_q == $past(bu_stage_q) && otd_act_q == $past(otd_stage_q)));
  p_stage_frozen_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_q |=> ($stable(bu_stage_q) && $stable(otd_stage_q)));
  p_active_steady_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !start_i |=> ($stable(bu_act_q) && $stable(otd_act_q)));
endmodule

// File: rtl/pwm_phase_acc.sv
module pwm_phase_acc
  import pwm_accum_pkg::*;
#(
  parameter int unsigned BU_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [BU_W-1:0]  inc_i,
  output logic [OTD_W-1:0] top_o,
  output logic             start_o
);
  localparam int unsigned ACC_W = BU_W + OTD_W;

  logic [ACC_W-1:0] acc_q;
  logic [ACC_W:0]   sum;
  logic             first_q;

  assign sum     = {1'b0, acc_q} + {{(ACC_W + 1 - BU_W){1'b0}}, inc_i};
  assign start_o = en_i & (first_q | sum[ACC_W]);
  assign top_o   = acc_q[ACC_W-1 -: OTD_W];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q   <= '0;
      first_q <= 1'b1;
    end else if (!en_i) begin
      acc_q   <= '0;
      first_q <= 1'b1;
    end else begin
      acc_q   <= sum[ACC_W-1:0];
      first_q <= 1'b0;
    end
  end

  p_hold_zero_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (acc_q == '0));
  p_restart_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && first_q) |-> (acc_q == '0));
  p_stall_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && inc_i == '0) |=> $stable(acc_q));
endmodule

// File: rtl/pwm_duty_cmp.sv
module pwm_duty_cmp
  import pwm_accum_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [OTD_W-1:0] top_i,
  input  logic [OTD_W-1:0] otd_i,
  output logic             pwm_o
);
  logic pwm_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pwm_q <= 1'b0;
    else         pwm_q <= en_i & (top_i > otd_i);
  end

  assign pwm_o = pwm_q;

  p_off_low_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> !pwm_o);
  p_max_div_low_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (otd_i == {OTD_W{1'b1}}) |=> !pwm_o);
endmodule

// File: rtl/pwm_accum_top.sv
module pwm_accum_top
  import pwm_accum_pkg::*;
#(
  parameter int unsigned BASE_UNIT_BITS = 8
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        wr_en_i,
  input  logic [31:0] wr_data_i,
  output logic [31:0] rd_data_o,
  output logic        pwm_o
);
  logic                      en;
  logic                      start;
  logic [BASE_UNIT_BITS-1:0] bu_act;
  logic [OTD_W-1:0]          otd_act;
  logic [OTD_W-1:0]          top;

  pwm_ctrl_reg #(.BU_W(BASE_UNIT_BITS)) u_reg (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en_i),
    .wr_data_i (wr_data_i),
    .start_i   (start),
    .en_o      (en),
    .bu_act_o  (bu_act),
    .otd_act_o (otd_act),
    .rd_data_o (rd_data_o)
  );

  pwm_phase_acc #(.BU_W(BASE_UNIT_BITS)) u_acc (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .en_i    (en),
    .inc_i   (bu_act),
    .top_o   (top),
    .start_o (start)
  );

  pwm_duty_cmp u_cmp (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (en),
    .top_i  (top),
    .otd_i  (otd_act),
    .pwm_o  (pwm_o)
  );

  p_reset_low_r9: assert property (@(posedge clk_i) $rose(rst_ni) |-> (!pwm_o && rd_data_o == '0));
  p_flag_set_only_on_write_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rd_data_o[UPD_BIT] && !wr_en_i) |=> !rd_data_o[UPD_BIT]);
endmodule

// File: tb/pwm_accum_top_tb_top.sv
module pwm_accum_top_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int ACC_MOD = 65536;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_en_i = 1'b0;
  logic [31:0] wr_data_i = '0;
  logic [31:0] rd_data_o;
  logic        pwm_o;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD / 2) clk_i = ~clk_i;

  pwm_accum_top dut_i (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en_i),
    .wr_data_i (wr_data_i),
    .rd_data_o (rd_data_o),
    .pwm_o     (pwm_o)
  );

  // behavioural reference state
  int m_en, m_upd, m_bu_s, m_otd_s, m_bu_a, m_otd_a, m_acc, m_first, m_pwm;
  int n_en, n_upd, n_bu_s, n_otd_s, n_bu_a, n_otd_a, n_acc, n_first, n_pwm;
  bit m_start;

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_en = 0; m_upd = 0; m_bu_s = 0; m_otd_s = 0; m_bu_a = 0; m_otd_a = 0;
      m_acc = 0; m_first = 1; m_pwm = 0;
    end else begin
      m_start = (m_en != 0) && (m_first != 0 || (m_acc + m_bu_a) >= ACC_MOD);
      n_pwm   = (m_en != 0 && (m_acc / 256) > m_otd_a) ? 1 : 0;
      n_acc   = (m_en != 0) ? (m_acc + m_bu_a) % ACC_MOD : 0;
      n_first = (m_en != 0) ? 0 : 1;
      n_bu_a = m_bu_a; n_otd_a = m_otd_a; n_bu_s = m_bu_s; n_otd_s = m_otd_s;
      n_en = m_en; n_upd = m_upd;
      if (m_upd != 0 && m_start) begin
        n_bu_a = m_bu_s; n_otd_a = m_otd_s; n_upd = 0;
      end
      if (wr_en_i) begin
        n_en = int'(wr_data_i[31]);
        if (m_upd == 0) begin
          n_upd = int'(wr_data_i[30]);
          n_bu_s = int'(wr_data_i[15:8]);
          n_otd_s = int'(wr_data_i[7:0]);
        end
      end
      m_en = n_en; m_upd = n_upd; m_bu_s = n_bu_s; m_otd_s = n_otd_s;
      m_bu_a = n_bu_a; m_otd_a = n_otd_a; m_acc = n_acc; m_first = n_first; m_pwm = n_pwm;
    end
  end

  function automatic logic [31:0] model_rd();
    logic [31:0] r;
    r = '0;
    r[31] = m_en[0];
    r[30] = m_upd[0];
    r[15:8] = m_bu_s[7:0];
    r[7:0] = m_otd_s[7:0];
    return r;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // every-clock comparison against the reference
  always @(negedge clk_i) begin
    if (rst_ni && !done) begin
      chk("R7 readback vs model", rd_data_o, model_rd());
      chk("R10 pwm vs model", {31'b0, pwm_o}, m_pwm[31:0]);
    end
  end

  function automatic logic [31:0] word(input bit en, input bit upd, input int bu, input int otd);
    return {en, upd, 14'b0, bu[7:0], otd[7:0]};
  endfunction

  task automatic wr(input logic [31:0] d);
    @(negedge clk_i);
    wr_en_i = 1'b1;
    wr_data_i = d;
    @(posedge clk_i);
    @(negedge clk_i);
    wr_en_i = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk_i);
  endtask

  task automatic wait_flag_clear();
    for (int i = 0; i < 70000; i++) begin
      if (!rd_data_o[30]) break;
      @(negedge clk_i);
    end
  endtask

  task automatic count_high(input int n, output int hi);
    hi = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk_i);
      if (pwm_o) hi++;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 190000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    int hi, t0, n;
    idle(3);
    @(negedge clk_i);
    // R9: reset state
    chk("R9 reset readback", rd_data_o, 32'h0);
    chk("R9 reset output", {31'b0, pwm_o}, 32'h0);
    rst_ni = 1'b1;
    idle(2);

    // R2/R3: enable with base unit 64, divisor 128
    wr(word(1, 1, 64, 128));
    chk("R2 flag set after write", {31'b0, rd_data_o[30]}, 32'h1);
    idle(1);
    chk("R2 flag cleared at first boundary", {31'b0, rd_data_o[30]}, 32'h0);
    idle(1100);
    // R3: interval between rising edges
    for (int i = 0; i < 2000; i++) begin
      @(negedge clk_i);
      if (pwm_o) break;
    end
    for (int i = 0; i < 2000; i++) begin
      @(negedge clk_i);
      if (!pwm_o) break;
    end
    t0 = 0;
    for (int i = 0; i < 2000; i++) begin
      @(negedge clk_i);
      t0++;
      if (pwm_o) break;
    end
    n = 0;
    for (int i = 0; i < 2000; i++) begin
      @(negedge clk_i);
      n++;
      if (!pwm_o) break;
    end
    for (int i = 0; i < 2000; i++) begin
      @(negedge clk_i);
      n++;
      if (pwm_o) break;
    end
    chk("R3 period in clocks", n, 1024);
    // R4: divisor 128 high for 127 of 256 top-byte values -> 508 of 1024
    count_high(1024, hi);
    chk("R4 high clocks divisor 128", hi, 508);

    // R6: second write while flag pending is ignored for fields
    wr(word(1, 1, 64, 0));
    wr(word(1, 0, 32, 77));
    chk("R6 staged fields kept", {16'b0, rd_data_o[15:0]}, {16'b0, 8'd64, 8'd0});
    chk("R6 enable still written", {31'b0, rd_data_o[31]}, 32'h1);
    wait_flag_clear();
    idle(50);
    count_high(1024, hi);
    chk("R4 divisor 0 nearly always high", hi, 1020);

    wr(word(1, 1, 64, 255));
    wait_flag_clear();
    idle(5);
    count_high(2048, hi);
    chk("R4 divisor 255 always low", hi, 0);

    // R5: base unit zero
    wr(word(1, 1, 0, 10));
    wait_flag_clear();
    idle(5);
    count_high(2000, hi);
    chk("R5 zero base unit output low", hi, 0);
    wr(word(1, 1, 64, 10));
    idle(2000);
    chk("R5 no boundary so flag stays set", {31'b0, rd_data_o[30]}, 32'h1);

    // R1: disable while flag pending; the boundary comes from the next enable
    wr(word(0, 0, 0, 0));
    chk("R1 enable clear readback", {31'b0, rd_data_o[31]}, 32'h0);
    count_high(500, hi);
    chk("R1 output low while disabled", hi, 0);
    wr(word(1, 0, 0, 0));
    idle(1);
    chk("R2 pending flag cleared by enable boundary", {31'b0, rd_data_o[30]}, 32'h0);
    wr(word(0, 0, 0, 0));
    idle(20);

    // R8: restart from zero gives full first cycle
    @(negedge clk_i);
    wr_en_i = 1'b1;
    wr_data_i = word(1, 1, 128, 64);
    @(posedge clk_i);
    @(negedge clk_i);
    wr_en_i = 1'b0;
    n = 0;
    for (int i = 0; i < 2000; i++) begin
      if (pwm_o) break;
      @(posedge clk_i);
      n++;
      @(negedge clk_i);
    end
    chk("R8 first high after restart", n, 132);
    idle(1500);

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule